// File: doc/BRIEF.md
# USB host non-transaction interrupt unit

This block holds the status and interrupt logic of a USB 1.1 class host controller for events that do not come from a finished transfer. It watches each transfer descriptor the schedule engine fetches for signs of corruption, listens for error strobes from the system bus interface, and takes resume strobes from the root ports. A corrupted descriptor or a bus error is fatal: the block halts the schedule, drops the run bit and raises an interrupt that no enable bit can mask. A resume during global suspend sets its own status bit, and only that source is gated by the enable register.

A second, always-powered part keeps the global suspend bit and the per-port resume, enabled, low-speed and suspend bits. It is cleared only by a separate power-on reset, so the port state survives a deep sleep. A resume seen while the system sleeps sets a wake status bit, which turns into a wake request when USB wake is enabled.

The schedule follows a three-state machine. HC_STOPPED goes to HC_RUNNING when the run bit is set and no fatal status bit is pending. HC_RUNNING goes to HC_STOPPED when software clears the run bit. HC_FAULT is entered from any state on a fatal error. It is left once both fatal status bits are clear: to HC_RUNNING if the run bit is set, otherwise to HC_STOPPED. The halted flag is high in every state except HC_RUNNING.

Top module: `usbint_ctrl`

## Requirements
- R1: While the main reset is held, the status bits, the enable bits and the run bit read 0, halted reads 1 and the interrupt is low.
- R2: A fetched descriptor whose PID byte is not 0x69, 0xE1 or 0x2D sets the process-error status bit (bit 2) on the next clock edge.
- R3: A fetched descriptor whose maximum-length field is 1280 or more sets status bit 2 on the next clock edge. A value of 1279 or less sets nothing.
- R4: A fatal error (process error or system error) sets halted and clears the run bit on the next clock edge.
- R5: A parity error, master abort or target abort strobe from the system bus sets the system-error status bit (bit 1) on the next clock edge.
- R6: The interrupt is high whenever bit 1 or bit 2 is set, whatever the enable register holds. Enable bits 1 and 2 are stored but have no effect.
- R7: A resume strobe on any port while global suspend is set sets the resume status bit (bit 0). That bit drives the interrupt only when enable bit 0 is set. A resume strobe without global suspend leaves bit 0 clear.
- R8: Writing a one to a status bit through the clear mask clears it. A zero leaves it unchanged, and a new event in the same cycle takes priority over the clear.
- R9: Writing the run bit to 1 while a fatal status bit is still set keeps halted high. Halted falls two clock edges after the write that clears the last fatal bit, provided the run bit is set.
- R10: The main reset leaves the global suspend bit and all port bits unchanged. Only the power-on reset clears them.
- R11: While the sleep input is low, the kept port enabled, low-speed and suspend bits follow their inputs one edge later. While sleep is high, they hold their values.
- R12: A resume strobe while sleep is high sets the wake status bit. The wake request equals wake status AND the wake-enable input. The wake status bit clears through its clear strobe.
- R13: Each port's kept resume-detect bit sets on that port's resume strobe and clears when one is written to its bit of the port clear mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main reset, active low |
| por_n | input | 1 | Power-on reset for the always-powered bits, active low |
| desc_vld | input | 1 | A descriptor was fetched this cycle |
| desc_pid | input | 8 | PID byte of the fetched descriptor |
| desc_maxlen | input | LEN_W | Maximum-length field of the fetched descriptor |
| bus_par_err | input | 1 | System bus parity error strobe |
| bus_mabort | input | 1 | System bus master abort strobe |
| bus_tabort | input | 1 | System bus target abort strobe |
| port_resume | input | NPORTS | Per-port resume-detect strobes |
| sts_clr_we | input | 1 | Status write strobe |
| sts_clr_mask | input | 3 | Write-one-to-clear mask (bit 0 resume, bit 1 system error, bit 2 process error) |
| ien_we | input | 1 | Enable register write strobe |
| ien_din | input | 3 | Enable register write data |
| cmd_we | input | 1 | Command write strobe |
| cmd_run | input | 1 | Run bit write data |
| cmd_egsm | input | 1 | Global suspend bit write data |
| port_rd_clr | input | NPORTS | Write-one-to-clear mask for the kept resume-detect bits |
| port_en_i | input | NPORTS | Live port enabled state |
| port_ls_i | input | NPORTS | Live low-speed-attached state |
| port_susp_i | input | NPORTS | Live port suspend state |
| sleep_i | input | 1 | System is in a deep sleep state |
| wake_en_i | input | 1 | USB wake enable |
| wake_clr | input | 1 | Clear strobe for the wake status bit |
| sts_o | output | 3 | Status bits |
| ien_o | output | 3 | Enable register |
| run_stop_o | output | 1 | Run bit |
| hc_halted_o | output | 1 | Schedule halted flag |
| irq_o | output | 1 | Interrupt |
| egsm_o | output | 1 | Kept global suspend bit |
| port_rd_o | output | NPORTS | Kept per-port resume-detect bits |
| port_en_o | output | NPORTS | Kept port enabled bits |
| port_ls_o | output | NPORTS | Kept low-speed-attached bits |
| port_susp_o | output | NPORTS | Kept port suspend bits |
| wake_sts_o | output | 1 | Wake status bit |
| wake_req_o | output | 1 | Wake request |

## Verification
The assertions assume that strobes last one cycle and that a status clear is not written while the main reset is active. They also assume the power-on reset is applied before the main reset is released, so both domains start from a known state. The stimulus drives every strobe for exactly one cycle on the falling edge, applies the power-on reset first, and issues writes only after both resets are released. The PID byte is swept through all 256 values and the length field through all 2048 values, with a clear-and-restart sequence before each descriptor so that every case starts in HC_RUNNING.

// File: rtl/usbint_pkg.sv
`timescale 1ns/1ps
package usbint_pkg;

    localparam int STS_W       = 3;
    localparam int STS_RESUME  = 0;
    localparam int STS_SYSERR  = 1;
    localparam int STS_PROCERR = 2;

    localparam logic [7:0] PID_TOKEN_IN    = 8'h69;
    localparam logic [7:0] PID_TOKEN_OUT   = 8'hE1;
    localparam logic [7:0] PID_TOKEN_SETUP = 8'h2D;

    typedef enum logic [1:0] {
        HC_STOPPED = 2'd0,
        HC_RUNNING = 2'd1,
        HC_FAULT   = 2'd2
    } hc_state_e;

    function automatic logic pid_is_legal(input logic [7:0] pid);
        return (pid == PID_TOKEN_IN) || (pid == PID_TOKEN_OUT) ||
               (pid == PID_TOKEN_SETUP);
    endfunction

endpackage

// File: rtl/usbint_desc_chk.sv
`timescale 1ns/1ps
module usbint_desc_chk
    import usbint_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int LEN_LIMIT = 1280
) (
    input  logic             desc_vld,
    input  logic [7:0]       desc_pid,
    input  logic [LEN_W-1:0] desc_maxlen,
    output logic             proc_err
);

    localparam logic [LEN_W-1:0] LIMIT_V = LEN_W'(LEN_LIMIT);

    logic pid_bad;
    logic len_bad;

    always_comb begin
        pid_bad  = !pid_is_legal(desc_pid);
        len_bad  = (desc_maxlen >= LIMIT_V);
        proc_err = desc_vld && (pid_bad || len_bad);
    end

endmodule

// File: rtl/usbint_sched_fsm.sv
`timescale 1ns/1ps
module usbint_sched_fsm
    import usbint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fatal_evt,
    input  logic fatal_sts,
    input  logic cmd_we,
    input  logic cmd_run,
    output logic run_stop,
    output logic hc_halted
);

    hc_state_e state_q;
    hc_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HC_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (fatal_evt) begin
            state_d = HC_FAULT;
        end else begin
            unique case (state_q)
                HC_STOPPED: if (run_stop && !fatal_sts) state_d = HC_RUNNING;
                HC_RUNNING: if (!run_stop) state_d = HC_STOPPED;
                HC_FAULT:   if (!fatal_sts) state_d = run_stop ? HC_RUNNING : HC_STOPPED;
                default:    state_d = HC_STOPPED;
            endcase
        end
    end

    // run bit: a fatal error overrides a software write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_stop <= 1'b0;
        end else if (fatal_evt) begin
            run_stop <= 1'b0;
        end else if (cmd_we) begin
            run_stop <= cmd_run;
        end
    end

    // outputs
    always_comb begin
        hc_halted = (state_q != HC_RUNNING);
    end

    // R4
    fault_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_evt |=> (hc_halted && !run_stop));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_sts |=> hc_halted);

    // R9
    run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HC_STOPPED && run_stop && !fatal_sts && !fatal_evt && !cmd_we)
        |=> !hc_halted);

endmodule

// File: rtl/usbint_status.sv
`timescale 1ns/1ps
module usbint_status
    import usbint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proc_err,
    input  logic             sys_err,
    input  logic             resume_evt,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_mask,
    input  logic             ien_we,
    input  logic [STS_W-1:0] ien_din,
    output logic [STS_W-1:0] sts,
    output logic [STS_W-1:0] ien,
    output logic             fatal_sts,
    output logic             irq
);

    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] clr_vec;
    logic [STS_W-1:0] sts_d;
    logic [STS_W-1:0] gate_vec;

    always_comb begin
        set_vec              = '0;
        set_vec[STS_RESUME]  = resume_evt;
        set_vec[STS_SYSERR]  = sys_err;
        set_vec[STS_PROCERR] = proc_err;
        clr_vec              = clr_we ? clr_mask : '0;
    end

    // new events win over a clear written in the same cycle
    for (genvar b = 0; b < STS_W; b++) begin : g_sts
        assign sts_d[b] = set_vec[b] | (sts[b] & ~clr_vec[b]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= sts_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (ien_we) begin
            ien <= ien_din;
        end
    end

    // only the resume source passes through the enable register
    always_comb begin
        gate_vec              = '1;
        gate_vec[STS_RESUME]  = ien[STS_RESUME];
        fatal_sts             = sts[STS_SYSERR] | sts[STS_PROCERR];
        irq                   = |(sts & gate_vec);
    end

    // R2
    procerr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_err |=> sts[STS_PROCERR]);

    // R5
    syserr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err |=> sts[STS_SYSERR]);

    // R6
    fatal_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_err || sys_err) |=> irq);

    // R7
    resume_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_evt && ien[STS_RESUME] && !ien_we) |=> irq);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[STS_RESUME] && !resume_evt) |=> !sts[STS_RESUME]);

endmodule

// File: rtl/usbint_keep.sv
`timescale 1ns/1ps
module usbint_keep #(
    parameter int NPORTS = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sleep_i,
    input  logic              egsm_we,
    input  logic              egsm_din,
    input  logic [NPORTS-1:0] port_resume,
    input  logic [NPORTS-1:0] port_rd_clr,
    input  logic [NPORTS-1:0] port_en_i,
    input  logic [NPORTS-1:0] port_ls_i,
    input  logic [NPORTS-1:0] port_susp_i,
    input  logic              wake_en_i,
    input  logic              wake_clr,
    output logic              egsm,
    output logic [NPORTS-1:0] port_rd,
    output logic [NPORTS-1:0] port_en,
    output logic [NPORTS-1:0] port_ls,
    output logic [NPORTS-1:0] port_susp,
    output logic              wake_sts,
    output logic              wake_req
);

    logic [NPORTS-1:0] rd_d;
    logic [NPORTS-1:0] en_d;
    logic [NPORTS-1:0] ls_d;
    logic [NPORTS-1:0] susp_d;
    logic              any_resume;

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        assign rd_d[i]   = port_resume[i] | (port_rd[i] & ~port_rd_clr[i]);
        assign en_d[i]   = sleep_i ? port_en[i]   : port_en_i[i];
        assign ls_d[i]   = sleep_i ? port_ls[i]   : port_ls_i[i];
        assign susp_d[i] = sleep_i ? port_susp[i] : port_susp_i[i];

        // R13
        port_rd_set_chk: assert property (@(posedge clk) disable iff (!por_n)
            port_resume[i] |=> port_rd[i]);
    end

    assign any_resume = |port_resume;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            egsm      <= 1'b0;
            port_rd   <= '0;
            port_en   <= '0;
            port_ls   <= '0;
            port_susp <= '0;
            wake_sts  <= 1'b0;
        end else begin
            if (egsm_we) begin
                egsm <= egsm_din;
            end
            port_rd   <= rd_d;
            port_en   <= en_d;
            port_ls   <= ls_d;
            port_susp <= susp_d;
            wake_sts  <= (sleep_i && any_resume) || (wake_sts && !wake_clr);
        end
    end

    always_comb begin
        wake_req = wake_sts && wake_en_i;
    end

    // R11
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        sleep_i |=> ($stable(port_en) && $stable(port_ls) && $stable(port_susp)));

    // R12
    wake_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sleep_i && any_resume) |=> wake_sts);

endmodule

// File: rtl/usbint_ctrl.sv
`timescale 1ns/1ps
module usbint_ctrl
    import usbint_pkg::*;
#(
    parameter int NPORTS    = 2,
    parameter int LEN_W     = 11,
    parameter int LEN_LIMIT = 1280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              desc_vld,
    input  logic [7:0]        desc_pid,
    input  logic [LEN_W-1:0]  desc_maxlen,
    input  logic              bus_par_err,
    input  logic              bus_mabort,
    input  logic              bus_tabort,
    input  logic [NPORTS-1:0] port_resume,
    input  logic              sts_clr_we,
    input  logic [2:0]        sts_clr_mask,
    input  logic              ien_we,
    input  logic [2:0]        ien_din,
    input  logic              cmd_we,
    input  logic              cmd_run,
    input  logic              cmd_egsm,
    input  logic [NPORTS-1:0] port_rd_clr,
    input  logic [NPORTS-1:0] port_en_i,
    input  logic [NPORTS-1:0] port_ls_i,
    input  logic [NPORTS-1:0] port_susp_i,
    input  logic              sleep_i,
    input  logic              wake_en_i,
    input  logic              wake_clr,
    output logic [2:0]        sts_o,
    output logic [2:0]        ien_o,
    output logic              run_stop_o,
    output logic              hc_halted_o,
    output logic              irq_o,
    output logic              egsm_o,
    output logic [NPORTS-1:0] port_rd_o,
    output logic [NPORTS-1:0] port_en_o,
    output logic [NPORTS-1:0] port_ls_o,
    output logic [NPORTS-1:0] port_susp_o,
    output logic              wake_sts_o,
    output logic              wake_req_o
);

    logic proc_err;
    logic sys_err;
    logic fatal_evt;
    logic fatal_sts;
    logic resume_evt;

    usbint_desc_chk #(
        .LEN_W     (LEN_W),
        .LEN_LIMIT (LEN_LIMIT)
    ) u_desc_chk (
        .desc_vld    (desc_vld),
        .desc_pid    (desc_pid),
        .desc_maxlen (desc_maxlen),
        .proc_err    (proc_err)
    );

    always_comb begin
        sys_err    = bus_par_err | bus_mabort | bus_tabort;
        fatal_evt  = proc_err | sys_err;
        resume_evt = (|port_resume) & egsm_o;
    end

    usbint_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .proc_err   (proc_err),
        .sys_err    (sys_err),
        .resume_evt (resume_evt),
        .clr_we     (sts_clr_we),
        .clr_mask   (sts_clr_mask),
        .ien_we     (ien_we),
        .ien_din    (ien_din),
        .sts        (sts_o),
        .ien        (ien_o),
        .fatal_sts  (fatal_sts),
        .irq        (irq_o)
    );

    usbint_sched_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fatal_evt (fatal_evt),
        .fatal_sts (fatal_sts),
        .cmd_we    (cmd_we),
        .cmd_run   (cmd_run),
        .run_stop  (run_stop_o),
        .hc_halted (hc_halted_o)
    );

    usbint_keep #(
        .NPORTS (NPORTS)
    ) u_keep (
        .clk         (clk),
        .por_n       (por_n),
        .sleep_i     (sleep_i),
        .egsm_we     (cmd_we),
        .egsm_din    (cmd_egsm),
        .port_resume (port_resume),
        .port_rd_clr (port_rd_clr),
        .port_en_i   (port_en_i),
        .port_ls_i   (port_ls_i),
        .port_susp_i (port_susp_i),
        .wake_en_i   (wake_en_i),
        .wake_clr    (wake_clr),
        .egsm        (egsm_o),
        .port_rd     (port_rd_o),
        .port_en     (port_en_o),
        .port_ls     (port_ls_o),
        .port_susp   (port_susp_o),
        .wake_sts    (wake_sts_o),
        .wake_req    (wake_req_o)
    );

endmodule

// File: tb/usbint_ctrl_test.sv
`timescale 1ns/1ps
module usbint_ctrl_test;

    localparam int NP  = 2;
    localparam int LW  = 11;
    localparam int LIM = 1280;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0, por_n = 1'b0;
    logic          desc_vld = 1'b0;
    logic [7:0]    desc_pid = '0;
    logic [LW-1:0] desc_maxlen = '0;
    logic          bus_par_err = 1'b0, bus_mabort = 1'b0, bus_tabort = 1'b0;
    logic [NP-1:0] port_resume = '0, port_rd_clr = '0;
    logic          sts_clr_we = 1'b0;
    logic [2:0]    sts_clr_mask = '0;
    logic          ien_we = 1'b0;
    logic [2:0]    ien_din = '0;
    logic          cmd_we = 1'b0, cmd_run = 1'b0, cmd_egsm = 1'b0;
    logic [NP-1:0] port_en_i = '0, port_ls_i = '0, port_susp_i = '0;
    logic          sleep_i = 1'b0, wake_en_i = 1'b0, wake_clr = 1'b0;

    logic [2:0]    sts_o, ien_o;
    logic          run_stop_o, hc_halted_o, irq_o, egsm_o, wake_sts_o, wake_req_o;
    logic [NP-1:0] port_rd_o, port_en_o, port_ls_o, port_susp_o;

    usbint_ctrl #(.NPORTS(NP), .LEN_W(LW), .LEN_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .desc_vld(desc_vld), .desc_pid(desc_pid), .desc_maxlen(desc_maxlen),
        .bus_par_err(bus_par_err), .bus_mabort(bus_mabort), .bus_tabort(bus_tabort),
        .port_resume(port_resume),
        .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
        .ien_we(ien_we), .ien_din(ien_din),
        .cmd_we(cmd_we), .cmd_run(cmd_run), .cmd_egsm(cmd_egsm),
        .port_rd_clr(port_rd_clr),
        .port_en_i(port_en_i), .port_ls_i(port_ls_i), .port_susp_i(port_susp_i),
        .sleep_i(sleep_i), .wake_en_i(wake_en_i), .wake_clr(wake_clr),
        .sts_o(sts_o), .ien_o(ien_o), .run_stop_o(run_stop_o),
        .hc_halted_o(hc_halted_o), .irq_o(irq_o), .egsm_o(egsm_o),
        .port_rd_o(port_rd_o), .port_en_o(port_en_o), .port_ls_o(port_ls_o),
        .port_susp_o(port_susp_o), .wake_sts_o(wake_sts_o), .wake_req_o(wake_req_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // clear every status bit and set the run bit; HC_RUNNING after two edges
    task automatic restart(input logic egsm_val);
        sts_clr_we = 1'b1; sts_clr_mask = 3'b111;
        cmd_we = 1'b1; cmd_run = 1'b1; cmd_egsm = egsm_val;
        tick();
        sts_clr_we = 1'b0; sts_clr_mask = '0; cmd_we = 1'b0;
        tick();
    endtask

    function automatic logic pid_ok(input int p);
        return (p == 'h69) || (p == 'hE1) || (p == 'h2D);
    endfunction

    initial begin
        #150000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(); tick();
        // R1 reset state
        chk("R1 sts", 32'(sts_o), 0);
        chk("R1 ien", 32'(ien_o), 0);
        chk("R1 run", 32'(run_stop_o), 0);
        chk("R1 halted", 32'(hc_halted_o), 1);
        chk("R1 irq", 32'(irq_o), 0);
        por_n = 1'b1; rst_n = 1'b1;
        tick();

        // R2 exhaustive PID sweep
        for (int p = 0; p < 256; p++) begin
            logic bad;
            restart(1'b0);
            bad = !pid_ok(p);
            desc_vld = 1'b1; desc_pid = 8'(p); desc_maxlen = '0;
            tick();
            desc_vld = 1'b0;
            chk("R2 process error bit", 32'(sts_o[2]), 32'(bad));
            chk("R4 halted after process error", 32'(hc_halted_o), 32'(bad));
            chk("R4 run bit", 32'(run_stop_o), 32'(!bad));
        end

        // R3 exhaustive length sweep with a legal PID
        for (int l = 0; l < (1 << LW); l++) begin
            logic bad;
            restart(1'b0);
            bad = (l >= LIM);
            desc_vld = 1'b1; desc_pid = 8'hE1; desc_maxlen = LW'(l);
            tick();
            desc_vld = 1'b0;
            chk("R3 length check", 32'(sts_o[2]), 32'(bad));
        end

        // R5 R4 R6 each bus error kind, enable register all zero
        for (int k = 0; k < 3; k++) begin
            restart(1'b0);
            bus_par_err = (k == 0); bus_mabort = (k == 1); bus_tabort = (k == 2);
            tick();
            bus_par_err = 1'b0; bus_mabort = 1'b0; bus_tabort = 1'b0;
            chk("R5 system error bit", 32'(sts_o), 32'b010);
            chk("R4 run cleared", 32'(run_stop_o), 0);
            chk("R4 halted", 32'(hc_halted_o), 1);
            chk("R6 unmaskable irq", 32'(irq_o), 1);
        end

        // R9 run write while fatal bit pending
        restart(1'b0);
        chk("R9 running", 32'(hc_halted_o), 0);
        bus_mabort = 1'b1; tick(); bus_mabort = 1'b0;
        cmd_we = 1'b1; cmd_run = 1'b1; tick(); cmd_we = 1'b0;
        tick();
        chk("R9 run bit set", 32'(run_stop_o), 1);
        chk("R9 stays halted", 32'(hc_halted_o), 1);
        sts_clr_we = 1'b1; sts_clr_mask = 3'b010; tick(); sts_clr_we = 1'b0;
        chk("R9 halted one edge after clear", 32'(hc_halted_o), 1);
        tick();
        chk("R9 resumes two edges after clear", 32'(hc_halted_o), 0);

        // R7 resume under global suspend
        sts_clr_we = 1'b1; sts_clr_mask = 3'b111;
        cmd_we = 1'b1; cmd_run = 1'b0; cmd_egsm = 1'b1;
        tick();
        sts_clr_we = 1'b0; cmd_we = 1'b0;
        chk("R7 suspend bit", 32'(egsm_o), 1);
        port_resume = 2'b01; tick(); port_resume = '0;
        chk("R7 resume bit", 32'(sts_o), 32'b001);
        chk("R7 masked irq", 32'(irq_o), 0);
        ien_we = 1'b1; ien_din = 3'b001; tick(); ien_we = 1'b0;
        chk("R7 enabled irq", 32'(irq_o), 1);

        // R8 write-one-to-clear
        bus_par_err = 1'b1; tick(); bus_par_err = 1'b0;
        chk("R8 two bits set", 32'(sts_o), 32'b011);
        sts_clr_we = 1'b1; sts_clr_mask = 3'b001; tick(); sts_clr_we = 1'b0;
        chk("R8 selective clear", 32'(sts_o), 32'b010);
        sts_clr_we = 1'b1; sts_clr_mask = 3'b010; bus_tabort = 1'b1;
        tick();
        sts_clr_we = 1'b0; bus_tabort = 1'b0;
        chk("R8 set wins over clear", 32'(sts_o), 32'b010);
        sts_clr_we = 1'b1; sts_clr_mask = 3'b111; tick(); sts_clr_we = 1'b0;
        chk("R8 all clear", 32'(sts_o), 0);
        chk("R8 irq low", 32'(irq_o), 0);

        // R6 fatal enable bits have no effect
        ien_we = 1'b1; ien_din = 3'b110; tick(); ien_we = 1'b0;
        chk("R6 enable stored", 32'(ien_o), 32'b110);
        chk("R6 no irq without status", 32'(irq_o), 0);
        port_resume = 2'b01; tick(); port_resume = '0;
        chk("R6 resume not gated by bits 1 2", 32'(irq_o), 0);
        desc_vld = 1'b1; desc_pid = 8'h00; tick(); desc_vld = 1'b0;
        chk("R6 irq on process error", 32'(irq_o), 1);
        sts_clr_we = 1'b1; sts_clr_mask = 3'b111; tick(); sts_clr_we = 1'b0;

        // R7 no resume status without global suspend; R13 kept resume bits
        cmd_we = 1'b1; cmd_run = 1'b0; cmd_egsm = 1'b0; tick(); cmd_we = 1'b0;
        port_resume = 2'b10; tick(); port_resume = '0;
        chk("R7 no suspend no bit", 32'(sts_o[0]), 0);
        chk("R13 port bits set", 32'(port_rd_o), 32'b11);
        port_rd_clr = 2'b01; tick(); port_rd_clr = '0;
        chk("R13 port 0 cleared", 32'(port_rd_o), 32'b10);
        port_rd_clr = 2'b10; tick(); port_rd_clr = '0;
        chk("R13 port 1 cleared", 32'(port_rd_o), 0);

        // R10 kept bits survive main reset
        cmd_we = 1'b1; cmd_egsm = 1'b1; cmd_run = 1'b1; tick(); cmd_we = 1'b0;
        port_resume = 2'b01; port_en_i = 2'b11; port_ls_i = 2'b01; port_susp_i = 2'b10;
        tick();
        port_resume = '0;
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
        chk("R10 suspend kept", 32'(egsm_o), 1);
        chk("R10 port resume kept", 32'(port_rd_o), 32'b01);
        chk("R10 enabled kept", 32'(port_en_o), 32'b11);
        chk("R10 low speed kept", 32'(port_ls_o), 32'b01);
        chk("R10 main bits reset", 32'(run_stop_o), 0);
        por_n = 1'b0; tick();
        chk("R10 power-on clears suspend", 32'(egsm_o), 0);
        chk("R10 power-on clears port", 32'(port_rd_o), 0);
        por_n = 1'b1; tick();

        // R11 sleep freezes port bits
        port_en_i = 2'b10; port_ls_i = 2'b00; port_susp_i = 2'b00; tick();
        chk("R11 tracks awake", 32'(port_en_o), 32'b10);
        sleep_i = 1'b1; port_en_i = 2'b01; port_ls_i = 2'b11; port_susp_i = 2'b11;
        tick(); tick();
        chk("R11 enabled held", 32'(port_en_o), 32'b10);
        chk("R11 low speed held", 32'(port_ls_o), 0);
        chk("R11 suspend held", 32'(port_susp_o), 0);

        // R12 wake status and request
        wake_en_i = 1'b0; port_resume = 2'b10; tick(); port_resume = '0;
        chk("R12 wake status", 32'(wake_sts_o), 1);
        chk("R12 request gated", 32'(wake_req_o), 0);
        wake_en_i = 1'b1; #1;
        chk("R12 request enabled", 32'(wake_req_o), 1);
        wake_clr = 1'b1; tick(); wake_clr = 1'b0;
        chk("R12 wake cleared", 32'(wake_sts_o), 0);
        sleep_i = 1'b0; tick();
        chk("R11 tracks after wake", 32'(port_en_o), 32'b01);
        port_resume = 2'b01; tick(); port_resume = '0;
        chk("R12 no wake while awake", 32'(wake_sts_o), 0);

        finish_run();
    end

endmodule